// File: doc/BRIEF.md
# Receive Byte Queue with Read-Paced Interrupts

This block is an eight-entry, byte-wide queue that sits between a serial receiver and the data register a processor reads. The receiver presents each completed byte with a one-cycle strobe. The processor pops the oldest byte with a read strobe. The oldest byte is always visible on the read-data output, and a 4-bit count reports how many bytes are held.

With the queue enabled and the read-paced interrupt mode selected, the receive interrupt follows the processor's reads instead of a fill threshold. It pulses once when a byte lands in an empty queue. After that it pulses once after every read that leaves bytes behind, so the handler runs once per byte.

Two faults raise a one-cycle error interrupt and latch a sticky overrun flag:
- A byte that arrives while the queue is full replaces the newest stored byte.
- A read while the queue is empty is an underflow.

Software clears the overrun flag with a clear strobe. A flush strobe empties the queue in one cycle.

Top module: `rxq_fifo`

## Requirements
- R1: After reset, the level is 0, read data is 0x00, and rx_irq, err_irq and ovr_flag are all 0.
- R2: With q_en and pace_en both 1, a byte written into an empty queue (level 0 to 1) gives rx_irq high for exactly the cycle after that edge.
- R3: A read that leaves the level above 0 gives an rx_irq pulse. A read that leaves the queue empty gives none.
- R4: A byte written while the queue already holds data and no read happens raises no rx_irq. The level rises by one.
- R5: A byte written while the level is 8 and no read happens replaces the newest stored byte. The level stays 8, err_irq pulses for one cycle and ovr_flag is set. The older bytes keep their order.
- R6: A read while q_en is 1 and the level is 0 leaves the level at 0, pulses err_irq and sets ovr_flag.
- R7: A write and a read in the same cycle with the level above 0 both take effect and the level is unchanged. This is not an overflow even at level 8. rx_irq is decided on the level after the update.
- R8: A flush strobe sets the level to 0 in one cycle, whatever other strobes are present. It produces no rx_irq and does not change ovr_flag.
- R9: ovr_flag stays set until ovr_clr is strobed. If a fault and ovr_clr come in the same cycle, the flag stays set.
- R10: With q_en 1 and pace_en 0, bytes are stored but rx_irq stays 0. With q_en 0, the level is held at 0, and strobes neither store data nor raise err_irq.
- R11: rd_data shows the oldest stored byte in arrival order, and 0x00 when the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_en | input | 1 | Queue enable |
| pace_en | input | 1 | Read-paced interrupt mode enable |
| flush | input | 1 | Empty the queue |
| ovr_clr | input | 1 | Clear the sticky overrun flag |
| rx_stb | input | 1 | Received-byte strobe |
| rx_byte | input | 8 | Received byte |
| rd_stb | input | 1 | Processor read of the data register |
| rd_data | output | 8 | Oldest stored byte, 0x00 when empty |
| level | output | 4 | Number of stored bytes, 0 to 8 |
| rx_irq | output | 1 | Receive interrupt pulse |
| err_irq | output | 1 | Error interrupt pulse |
| ovr_flag | output | 1 | Sticky overrun and underflow flag |

## Verification
Every result of a strobe is due one cycle later. The level, the read data, both interrupt pulses and the overrun flag all change on the rising edge that takes the strobe, and the interrupt pulses fall again on the following edge. The bench drives strobes on the falling edge and checks every output 1 ns after the next rising edge. Each pulse is therefore seen in the single cycle it is due and not in the cycle before or after. Cases in which two strobes meet in one edge have their own checks: write with read, write with flush, fault with clear, and read with write into an empty queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Per-cycle decisions of the queue controller.
    typedef struct packed {
        logic push;      // a byte is stored this cycle
        logic pop;       // the oldest byte is consumed this cycle
        logic overflow;  // store replaces the newest entry
        logic underflow; // read of an empty queue
    } q_evt_t;

    // How the level moves this cycle.
    typedef enum logic [1:0] {
        LV_HOLD  = 2'd0,
        LV_UP    = 2'd1,
        LV_DOWN  = 2'd2,
        LV_CLEAR = 2'd3
    } lvl_act_e;

    // Choose the level action from the decided events.
    function automatic lvl_act_e pick_lvl_act(input logic clear, input q_evt_t e);
        if (clear)
            return LV_CLEAR;
        else if (e.push && !e.overflow && !e.pop)
            return LV_UP;
        else if (e.pop && !e.push)
            return LV_DOWN;
        else
            return LV_HOLD;
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             q_en,
    input  logic             flush,
    input  logic             rx_stb,
    input  logic             rd_stb,
    output q_evt_t           evt,
    output logic [LVL_W-1:0] lvl_q,
    output logic [LVL_W-1:0] lvl_d,
    output logic [PTR_W-1:0] waddr,
    output logic [PTR_W-1:0] raddr
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W-1:0] wr_ptr_inc, rd_ptr_inc, wr_ptr_dec;
    logic             active, is_empty, is_full, clear;
    lvl_act_e         act;

    assign active   = q_en && !flush;
    assign is_empty = (lvl_q == '0);
    assign is_full  = (lvl_q == FULL_LVL);
    assign clear    = flush || !q_en;

    assign wr_ptr_inc = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
    assign rd_ptr_inc = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
    assign wr_ptr_dec = (wr_ptr == '0) ? LAST_IDX : wr_ptr - 1'b1;

    always_comb begin
        evt           = '0;
        evt.pop       = active && rd_stb && !is_empty;
        evt.underflow = active && rd_stb && is_empty;
        evt.push      = active && rx_stb;
        evt.overflow  = active && rx_stb && is_full && !evt.pop;
    end

    assign act = pick_lvl_act(clear, evt);

    always_comb begin
        unique case (act)
            LV_UP:    lvl_d = lvl_q + 1'b1;
            LV_DOWN:  lvl_d = lvl_q - 1'b1;
            LV_CLEAR: lvl_d = '0;
            default:  lvl_d = lvl_q;
        endcase
    end

    // An overflowing byte goes to the slot written last.
    assign waddr = evt.overflow ? wr_ptr_dec : wr_ptr;
    assign raddr = rd_ptr;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            lvl_q  <= '0;
        end else begin
            lvl_q <= lvl_d;
            if (evt.push && !evt.overflow)
                wr_ptr <= wr_ptr_inc;
            if (evt.pop)
                rd_ptr <= rd_ptr_inc;
        end
    end

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= FULL_LVL);

    // R5
    overflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        evt.overflow |=> lvl_q == FULL_LVL);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> lvl_q == '0);

    // R7
    both_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.push && evt.pop) |=> lvl_q == $past(lvl_q));

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[i] <= '0;
            else if (we && waddr == PTR_W'(i))
                slot[i] <= wdata;
        end
    end

    assign rdata = slot[raddr];

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
    import rxq_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pace_act,
    input  logic             ovr_clr,
    input  q_evt_t           evt,
    input  logic [LVL_W-1:0] lvl_q,
    input  logic [LVL_W-1:0] lvl_d,
    output logic             rx_irq,
    output logic             err_irq,
    output logic             ovr_flag
);

    logic rx_fire, err_fire;

    // A byte landing in an empty queue, or a read that leaves data behind.
    assign rx_fire  = pace_act &&
                      ((evt.push && lvl_q == '0) || (evt.pop && lvl_d != '0));
    assign err_fire = evt.overflow || evt.underflow;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_irq   <= 1'b0;
            err_irq  <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            rx_irq  <= rx_fire;
            err_irq <= err_fire;
            if (err_fire)
                ovr_flag <= 1'b1;
            else if (ovr_clr)
                ovr_flag <= 1'b0;
        end
    end

    // R4
    no_irq_on_append_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.push && !evt.pop && lvl_q != '0) |=> !rx_irq);

    // R6
    underflow_err_chk: assert property (@(posedge clk) disable iff (rst)
        evt.underflow |=> (err_irq && ovr_flag));

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    // R10
    pace_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pace_act |=> !rx_irq);

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_en,
    input  logic              pace_en,
    input  logic              flush,
    input  logic              ovr_clr,
    input  logic              rx_stb,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  level,
    output logic              rx_irq,
    output logic              err_irq,
    output logic              ovr_flag
);

    localparam int PTR_W = $clog2(DEPTH);

    q_evt_t            evt;
    logic [LVL_W-1:0]  lvl_q, lvl_d;
    logic [PTR_W-1:0]  waddr, raddr;
    logic [DATA_W-1:0] head;

    rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .q_en   (q_en),
        .flush  (flush),
        .rx_stb (rx_stb),
        .rd_stb (rd_stb),
        .evt    (evt),
        .lvl_q  (lvl_q),
        .lvl_d  (lvl_d),
        .waddr  (waddr),
        .raddr  (raddr)
    );

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (evt.push),
        .waddr (waddr),
        .wdata (rx_byte),
        .raddr (raddr),
        .rdata (head)
    );

    rxq_irq #(.LVL_W(LVL_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .pace_act (q_en && pace_en),
        .ovr_clr  (ovr_clr),
        .evt      (evt),
        .lvl_q    (lvl_q),
        .lvl_d    (lvl_d),
        .rx_irq   (rx_irq),
        .err_irq  (err_irq),
        .ovr_flag (ovr_flag)
    );

    assign level   = lvl_q;
    assign rd_data = (lvl_q != '0) ? head : '0;

    // R11
    empty_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |-> (rd_data == '0));

endmodule

// File: tb/rxq_fifo_bench.sv
module rxq_fifo_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       q_en = 1'b1, pace_en = 1'b1, flush = 1'b0, ovr_clr = 1'b0;
    logic       rx_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] rd_data;
    logic [3:0] level;
    logic       rx_irq, err_irq, ovr_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rxq_fifo u_rxq_fifo (
        .clk(clk), .rst(rst), .q_en(q_en), .pace_en(pace_en), .flush(flush),
        .ovr_clr(ovr_clr), .rx_stb(rx_stb), .rx_byte(rx_byte), .rd_stb(rd_stb),
        .rd_data(rd_data), .level(level), .rx_irq(rx_irq), .err_irq(err_irq),
        .ovr_flag(ovr_flag)
    );

    // Vector fields: wr, byte, rd, level, rx_irq, err_irq, ovr_flag, rd_data
    localparam int NV = 12;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'hA0, 1'b0, 4'd1, 1'b1, 1'b0, 1'b0, 8'hA0}, // R2 write into empty
        {1'b1, 8'hA1, 1'b0, 4'd2, 1'b0, 1'b0, 1'b0, 8'hA0}, // R4
        {1'b1, 8'hA2, 1'b0, 4'd3, 1'b0, 1'b0, 1'b0, 8'hA0}, // R4
        {1'b0, 8'h00, 1'b1, 4'd2, 1'b1, 1'b0, 1'b0, 8'hA1}, // R3 R11
        {1'b0, 8'h00, 1'b0, 4'd2, 1'b0, 1'b0, 1'b0, 8'hA1}, // pulse ends
        {1'b1, 8'hA3, 1'b1, 4'd2, 1'b1, 1'b0, 1'b0, 8'hA2}, // R7
        {1'b0, 8'h00, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 8'hA3}, // R3
        {1'b0, 8'h00, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 empties
        {1'b0, 8'h00, 1'b1, 4'd0, 1'b0, 1'b1, 1'b1, 8'h00}, // R6 underflow
        {1'b1, 8'hA4, 1'b1, 4'd1, 1'b1, 1'b1, 1'b1, 8'hA4}, // R6 R2 read+write on empty
        {1'b0, 8'h00, 1'b1, 4'd0, 1'b0, 1'b0, 1'b1, 8'h00}, // R3 R9
        {1'b0, 8'h00, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 8'h00}  // R9 idle
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [3:0] lv, input logic rx,
                             input logic er, input logic ov, input logic [7:0] dt);
        check(req, "level",    32'(level),    32'(lv));
        check(req, "rx_irq",   32'(rx_irq),   32'(rx));
        check(req, "err_irq",  32'(err_irq),  32'(er));
        check(req, "ovr_flag", 32'(ovr_flag), 32'(ov));
        check(req, "rd_data",  32'(rd_data),  32'(dt));
    endtask

    // Drive on the falling edge, sample 1 ns after the next rising edge.
    task automatic step(input logic wr, input logic [7:0] b, input logic rd,
                        input logic fl, input logic clr);
        @(negedge clk);
        rx_stb = wr; rx_byte = b; rd_stb = rd; flush = fl; ovr_clr = clr;
        @(posedge clk);
        #1;
        rx_stb = 1'b0; rd_stb = 1'b0; flush = 1'b0; ovr_clr = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_all("R1", 4'd0, 1'b0, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][24], VEC[i][23:16], VEC[i][15], 1'b0, 1'b0);
            check_all($sformatf("vec%0d", i), VEC[i][14:11], VEC[i][10],
                      VEC[i][9], VEC[i][8], VEC[i][7:0]);
        end

        // R9: clear strobe clears the flag
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        check("R9", "ovr_flag after clear", 32'(ovr_flag), 32'd0);

        // R5: fill to 8, then overflow
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 8'hB0 + 8'(k), 1'b0, 1'b0, 1'b0);
            check("R2/R4", "rx_irq fill", 32'(rx_irq), (k == 0) ? 32'd1 : 32'd0);
        end
        check("R5", "level full", 32'(level), 32'd8);
        step(1'b1, 8'hC9, 1'b0, 1'b0, 1'b0);
        check_all("R5", 4'd8, 1'b0, 1'b1, 1'b1, 8'hB0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R5", "err_irq one cycle", 32'(err_irq), 32'd0);
        for (int k = 1; k <= 8; k++) begin
            step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
            if (k < 7)
                check("R11", "order", 32'(rd_data), 32'(8'hB0 + 8'(k)));
            else if (k == 7)
                check("R5", "newest replaced", 32'(rd_data), 32'hC9);
            check("R3", "read irq", 32'(rx_irq), (k < 8) ? 32'd1 : 32'd0);
        end
        check("R3", "level drained", 32'(level), 32'd0);

        // R7: write and read together while full
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++) step(1'b1, 8'hD0 + 8'(k), 1'b0, 1'b0, 1'b0);
        step(1'b1, 8'hE0, 1'b1, 1'b0, 1'b0);
        check_all("R7", 4'd8, 1'b1, 1'b0, 1'b0, 8'hD1);

        // R8: flush with a write in the same cycle
        step(1'b1, 8'hF0, 1'b0, 1'b1, 1'b0);
        check_all("R8", 4'd0, 1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b1, 8'h5A, 1'b0, 1'b0, 1'b0);
        check_all("R8", 4'd1, 1'b1, 1'b0, 1'b0, 8'h5A);

        // R9: fault and clear in the same cycle, flag kept; flush keeps flag
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
        check("R9", "set beats clear", 32'(ovr_flag), 32'd1);
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R8", "flush keeps ovr_flag", 32'(ovr_flag), 32'd1);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);

        // R10: pacing off stores silently
        pace_en = 1'b0;
        step(1'b1, 8'h77, 1'b0, 1'b0, 1'b0);
        check_all("R10", 4'd1, 1'b0, 1'b0, 1'b0, 8'h77);
        step(1'b1, 8'h78, 1'b1, 1'b0, 1'b0);
        check("R10", "no rx_irq on read", 32'(rx_irq), 32'd0);
        pace_en = 1'b1;

        // R10: queue disabled ignores strobes
        q_en = 1'b0;
        step(1'b1, 8'h99, 1'b0, 1'b0, 1'b0);
        check_all("R10", 4'd0, 1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        check_all("R10", 4'd0, 1'b0, 1'b0, 1'b0, 8'h00);
        q_en = 1'b1;

        // R1: reset returns to the idle state
        step(1'b1, 8'h42, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check_all("R1", 4'd0, 1'b0, 1'b0, 1'b0, 8'h00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule